// File: doc/BRIEF.md
# Two-Bank Interleaved Byte/Halfword Memory

This block is a byte-addressed memory of 2^ADDR_W bytes made of two byte-wide banks. Each bank holds 2^(ADDR_W-1) entries. Even global addresses live in bank 0 and odd global addresses live in bank 1, so any two neighbouring bytes sit in different banks. A halfword therefore takes one byte from each bank in a single cycle. A byte access always uses the low data lane. Halfwords are little-endian: the byte at the lower address is on bits 7..0.

A halfword at an odd address starts in bank 1. Its second byte comes from bank 0 at the next local address, so the lanes are crossed on both write and read. At the top of the address space that next local address wraps to 0. The parameter ALLOW_UNALIGNED chooses the mode. When it is 0, an odd-address halfword is rejected: nothing is written and an error flag is raised in place of read data.

Every cycle is an access. Read data and the error flag for a request appear on the outputs one clock after that request is presented.

Top module: `ilv_mem`

## Requirements
- R1: A byte at global address A is held in bank A[0] at local address A[ADDR_W-1:1]. A byte written at A reads back at A and at no other address.
- R2: rd_data_o and err_o reflect the request of the previous cycle. A read of a location in the same cycle as a write to it returns the old contents.
- R3: A byte read (size_i = 0) returns the byte on rd_data_o[7:0] and zero on rd_data_o[15:8], whichever bank holds it.
- R4: A byte write (size_i = 0, we_i = 1) changes only the addressed byte and takes its value from wr_data_i[7:0]. wr_data_i[15:8] has no effect.
- R5: A halfword access (size_i = 1) at an even address A uses local address A/2 in both banks. Bits 7..0 of the halfword map to byte A and bits 15..8 map to byte A+1.
- R6: With ALLOW_UNALIGNED = 1, a halfword at an odd address A maps bits 7..0 to byte A (bank 1) and bits 15..8 to byte A+1 (bank 0, local address plus one), for both reads and writes.
- R7: A halfword at the top address 2^ADDR_W-1 takes its upper byte from global address 0.
- R8: With ALLOW_UNALIGNED = 0, a halfword at an odd address writes nothing. In the following cycle it sets err_o = 1 and rd_data_o = 0.
- R9: err_o is 0 after every other access, and always 0 when ALLOW_UNALIGNED = 1.
- R10: While rst_i is high, rd_data_o and err_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Global byte address |
| size_i | input | 1 | Access size: 0 byte, 1 halfword |
| we_i | input | 1 | Write when 1, read when 0 |
| wr_data_i | input | 16 | Write data, lower address on bits 7..0 |
| rd_data_o | output | 16 | Read data for the previous cycle's request |
| err_o | output | 1 | Previous request was a rejected misaligned halfword |

## Verification
Faults in the address split or the lane crossing show up as wrong bytes in rd_data_o. They appear on the first later read that touches the affected location, which is why every byte and every halfword position is swept after each write pattern. A stale steering register puts the data of the wrong size or lane on the output one cycle after the request. A wrong write enable corrupts a neighbouring byte, or lets a rejected access leak into memory, and only a later full byte sweep can show that. The error flag is compared on every access in both modes.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    localparam int unsigned NBANK  = 2;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned HALF_W = 2 * BYTE_W;

    typedef enum logic {
        SZ_BYTE = 1'b0,
        SZ_HALF = 1'b1
    } acc_size_e;

    // Control needed to assemble the read data one cycle later
    typedef struct packed {
        logic      odd;
        acc_size_e size;
        logic      err;
    } steer_t;

    // Build the host-side read word from the two bank outputs
    function automatic logic [HALF_W-1:0] steer_read(steer_t c,
                                                     logic [BYTE_W-1:0] b0,
                                                     logic [BYTE_W-1:0] b1);
        logic [HALF_W-1:0] r;
        if (c.err)
            r = '0;
        else if (c.size == SZ_BYTE)
            r = {{BYTE_W{1'b0}}, (c.odd ? b1 : b0)};
        else if (c.odd)
            r = {b0, b1};
        else
            r = {b1, b0};
        return r;
    endfunction

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
    parameter int unsigned AW = 4,
    parameter int unsigned DW = 8
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic [AW-1:0] addr_i,
    input  logic          we_i,
    input  logic [DW-1:0] wd_i,
    output logic [DW-1:0] rd_o
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i)
            mem[addr_i] <= wd_i;
    end

    // read-before-write: old contents are captured on a same-cycle write
    always_ff @(posedge clk_i) begin
        if (rst_i)
            rd_o <= '0;
        else
            rd_o <= mem[addr_i];
    end

endmodule

// File: rtl/ilv_addr_map.sv
module ilv_addr_map
    import ilv_pkg::*;
#(
    parameter int unsigned ADDR_W          = 5,
    parameter bit          ALLOW_UNALIGNED = 1'b1,
    localparam int unsigned LW             = ADDR_W - 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  acc_size_e         size_i,
    input  logic              we_i,
    input  logic [HALF_W-1:0] wr_data_i,
    output logic [LW-1:0]     bank_addr_o [NBANK],
    output logic [NBANK-1:0]  bank_we_o,
    output logic [BYTE_W-1:0] bank_wd_o [NBANK],
    output steer_t            ctl_o
);
    logic          odd;
    logic [LW-1:0] loc;
    logic          misal;

    assign odd = addr_i[0];
    assign loc = addr_i[ADDR_W-1:1];

    generate
        if (ALLOW_UNALIGNED) begin : g_unaligned
            assign misal = 1'b0;
        end else begin : g_aligned
            assign misal = (size_i == SZ_HALF) && odd;
        end
    endgenerate

    always_comb begin
        bank_addr_o[1] = loc;
        // second byte of an odd halfword sits one local entry higher in bank 0
        bank_addr_o[0] = (odd && size_i == SZ_HALF) ? LW'(loc + 1'b1) : loc;

        if (size_i == SZ_BYTE) begin
            bank_wd_o[0] = wr_data_i[BYTE_W-1:0];
            bank_wd_o[1] = wr_data_i[BYTE_W-1:0];
            bank_we_o    = we_i ? (odd ? 2'b10 : 2'b01) : 2'b00;
        end else begin
            bank_wd_o[0] = odd ? wr_data_i[HALF_W-1:BYTE_W] : wr_data_i[BYTE_W-1:0];
            bank_wd_o[1] = odd ? wr_data_i[BYTE_W-1:0]      : wr_data_i[HALF_W-1:BYTE_W];
            bank_we_o    = (we_i && !misal) ? 2'b11 : 2'b00;
        end

        ctl_o.odd  = odd;
        ctl_o.size = size_i;
        ctl_o.err  = misal;
    end

endmodule

// File: rtl/ilv_read_steer.sv
module ilv_read_steer
    import ilv_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  steer_t            ctl_i,
    input  logic [BYTE_W-1:0] b0_i,
    input  logic [BYTE_W-1:0] b1_i,
    output logic [HALF_W-1:0] rd_data_o,
    output logic              err_o
);
    steer_t ctl_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)
            ctl_q <= '0;
        else
            ctl_q <= ctl_i;
    end

    assign rd_data_o = steer_read(ctl_q, b0_i, b1_i);
    assign err_o     = ctl_q.err;

endmodule

// File: rtl/ilv_mem.sv
module ilv_mem
    import ilv_pkg::*;
#(
    parameter int unsigned ADDR_W          = 5,
    parameter bit          ALLOW_UNALIGNED = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              size_i,
    input  logic              we_i,
    input  logic [15:0]       wr_data_i,
    output logic [15:0]       rd_data_o,
    output logic              err_o
);
    localparam int unsigned LW = ADDR_W - 1;

    logic [LW-1:0]     bank_addr [NBANK];
    logic [NBANK-1:0]  bank_we;
    logic [BYTE_W-1:0] bank_wd   [NBANK];
    logic [BYTE_W-1:0] bank_q    [NBANK];
    steer_t            ctl;

    ilv_addr_map #(
        .ADDR_W          (ADDR_W),
        .ALLOW_UNALIGNED (ALLOW_UNALIGNED)
    ) u_map (
        .addr_i      (addr_i),
        .size_i      (acc_size_e'(size_i)),
        .we_i        (we_i),
        .wr_data_i   (wr_data_i),
        .bank_addr_o (bank_addr),
        .bank_we_o   (bank_we),
        .bank_wd_o   (bank_wd),
        .ctl_o       (ctl)
    );

    generate
        for (genvar g = 0; g < NBANK; g++) begin : g_bank
            ilv_bank #(
                .AW (LW),
                .DW (BYTE_W)
            ) u_bank (
                .clk_i  (clk_i),
                .rst_i  (rst_i),
                .addr_i (bank_addr[g]),
                .we_i   (bank_we[g]),
                .wd_i   (bank_wd[g]),
                .rd_o   (bank_q[g])
            );
        end
    endgenerate

    ilv_read_steer u_steer (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .ctl_i     (ctl),
        .b0_i      (bank_q[0]),
        .b1_i      (bank_q[1]),
        .rd_data_o (rd_data_o),
        .err_o     (err_o)
    );

endmodule

// File: rtl/ilv_mem_chk.sv
module ilv_mem_chk #(
    parameter int unsigned ADDR_W          = 5,
    parameter bit          ALLOW_UNALIGNED = 1'b1
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              size_i,
    input logic              we_i,
    input logic [15:0]       rd_data_o,
    input logic              err_o,
    input logic [1:0]        bank_we
);
    logic reject;
    assign reject = size_i && addr_i[0] && (ALLOW_UNALIGNED == 1'b0);

    assert_reject_flag_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        reject |=> err_o);

    assert_reject_no_write_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        reject |-> (bank_we == 2'b00));

    assert_err_data_zero_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        err_o |-> (rd_data_o == 16'h0000));

    assert_err_quiet_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        !reject |=> !err_o);

    assert_byte_upper_zero_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        !size_i |=> (rd_data_o[15:8] == 8'h00));

    assert_byte_one_bank_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (we_i && !size_i) |-> (bank_we == (addr_i[0] ? 2'b10 : 2'b01)));

    assert_half_both_banks_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (we_i && size_i && !reject) |-> (bank_we == 2'b11));

    assert_read_no_write_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        !we_i |-> (bank_we == 2'b00));

endmodule

bind ilv_mem ilv_mem_chk #(
    .ADDR_W          (ADDR_W),
    .ALLOW_UNALIGNED (ALLOW_UNALIGNED)
) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .addr_i    (addr_i),
    .size_i    (size_i),
    .we_i      (we_i),
    .rd_data_o (rd_data_o),
    .err_o     (err_o),
    .bank_we   (bank_we)
);

// File: tb/ilv_mem_bench.sv
module ilv_mem_bench;
    localparam int AW = 5;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          size = 1'b0;
    logic          we = 1'b0;
    logic [15:0]   wdata = '0;
    logic [15:0]   rd_u, rd_a;
    logic          err_u, err_a;

    logic [7:0] mu [N];   // expected contents, unaligned instance
    logic [7:0] ma [N];   // expected contents, aligned instance

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    ilv_mem #(.ADDR_W(AW), .ALLOW_UNALIGNED(1'b1)) u_ilv_mem (
        .clk_i(clk), .rst_i(rst), .addr_i(addr), .size_i(size), .we_i(we),
        .wr_data_i(wdata), .rd_data_o(rd_u), .err_o(err_u));

    ilv_mem #(.ADDR_W(AW), .ALLOW_UNALIGNED(1'b0)) u_ilv_mem_aligned (
        .clk_i(clk), .rst_i(rst), .addr_i(addr), .size_i(size), .we_i(we),
        .wr_data_i(wdata), .rd_data_o(rd_a), .err_o(err_a));

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge with outputs for this request
    task automatic access(input int a, input logic sz, input logic w, input logic [15:0] d);
        addr  = AW'(a);
        size  = sz;
        we    = w;
        wdata = d;
        @(negedge clk);
    endtask

    function automatic logic [15:0] half_of(input logic [7:0] m [N], input int a);
        return {m[(a + 1) % N], m[a]};
    endfunction

    task automatic sweep_bytes(input string req);
        for (int a = 0; a < N; a++) begin
            access(a, 1'b0, 1'b0, 16'h0);
            chk(req, rd_u, {8'h00, mu[a]});
            chk(req, rd_a, {8'h00, ma[a]});
            chk("R9", {15'h0, err_u}, 16'h0);
            chk("R9", {15'h0, err_a}, 16'h0);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [15:0] d;
        repeat (3) @(negedge clk);
        // R10: outputs cleared while reset is held
        chk("R10", rd_u, 16'h0);
        chk("R10", {15'h0, err_u}, 16'h0);
        chk("R10", rd_a, 16'h0);
        chk("R10", {15'h0, err_a}, 16'h0);
        rst = 1'b0;

        // R1, R4: fill with byte writes; upper lane carries junk
        for (int a = 0; a < N; a++) begin
            d = {8'hA5 ^ 8'(a), 8'(a * 37 + 11)};
            access(a, 1'b0, 1'b1, d);
            mu[a] = d[7:0];
            ma[a] = d[7:0];
        end
        sweep_bytes("R1");
        sweep_bytes("R3");

        // R5, R6, R7, R8: halfword reads at every address
        for (int a = 0; a < N; a++) begin
            access(a, 1'b1, 1'b0, 16'h0);
            if (a % 2 == 0) begin
                chk("R5", rd_u, half_of(mu, a));
                chk("R5", rd_a, half_of(ma, a));
                chk("R9", {15'h0, err_a}, 16'h0);
            end else begin
                chk((a == N - 1) ? "R7" : "R6", rd_u, half_of(mu, a));
                chk("R8", rd_a, 16'h0);
                chk("R8", {15'h0, err_a}, 16'h1);
            end
            chk("R9", {15'h0, err_u}, 16'h0);
        end

        // R6, R7, R8: odd halfword writes, including the wrapping top address
        for (int a = 1; a < N; a += 2) begin
            d = 16'(a * 16'h0301) ^ 16'h3C5A;
            access(a, 1'b1, 1'b1, d);
            chk("R8", {15'h0, err_a}, 16'h1);
            chk("R9", {15'h0, err_u}, 16'h0);
            mu[a] = d[7:0];
            mu[(a + 1) % N] = d[15:8];
        end
        sweep_bytes("R6");   // aligned instance must be unchanged (R8)

        // R5: even halfword writes
        for (int a = 0; a < N; a += 4) begin
            d = 16'(a * 16'h1107) ^ 16'hC3E1;
            access(a, 1'b1, 1'b1, d);
            mu[a] = d[7:0];  mu[a + 1] = d[15:8];
            ma[a] = d[7:0];  ma[a + 1] = d[15:8];
        end
        sweep_bytes("R5");

        // R2: same-cycle read returns old data, next read sees new
        for (int a = 2; a < N; a += 8) begin
            d = 16'hBEEF ^ 16'(a);
            access(a, 1'b1, 1'b1, d);
            chk("R2", rd_u, half_of(mu, a));
            chk("R2", rd_a, half_of(ma, a));
            mu[a] = d[7:0];  mu[a + 1] = d[15:8];
            ma[a] = d[7:0];  ma[a + 1] = d[15:8];
            access(a, 1'b1, 1'b0, 16'h0);
            chk("R2", rd_u, half_of(mu, a));
            chk("R2", rd_a, half_of(ma, a));
        end

        // R4: odd byte writes touch only their byte
        for (int a = 1; a < N; a += 6) begin
            access(a, 1'b0, 1'b1, {8'hFF, 8'(a + 8'h40)});
            mu[a] = 8'(a + 8'h40);
            ma[a] = 8'(a + 8'h40);
        end
        sweep_bytes("R4");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule